// File: doc/BRIEF.md
# Protected Command Sequence Decoder

This block sits between the host write port of a two-bank flash and the engines that erase or program the array. Every write-type operation is guarded by an unlock handshake: a short series of write cycles that carry fixed key addresses and key codes. The decoder watches each write cycle and advances through a shared unlock sequence. When a sequence completes, it issues a single-cycle command pulse that carries the operation, the target bank, and the address and data of the final cycle. A cycle that does not fit the expected step drops the sequence and returns the decoder to read mode.

Three-cycle sequences select word program (a fourth cycle then carries the word), identification entry and identification exit. Six-cycle sequences select whole-bank, block and sector erase. While identification mode is active, the block answers reads with the maker code and a per-bank device code. While the array reports an operation in progress, every write cycle is ignored and the sequence position is kept.

Top module: `flash_unlock_decoder`

## Requirements
- R1: While rst_ni is low, and after it is released, cmd_valid_o is 0, id_mode_o is 0, id_data_o is 0000h, and the sequence position is cleared, so a sequence that was cut by reset must start again from its first cycle.
- R2: A program sequence is: cycle 1 at address 5555h with code AAh, cycle 2 at 2AAAh with code 55h, cycle 3 at 5555h with code A0h, and then any fourth cycle. The fourth cycle gives a pulse with cmd_op_o = 1 and cmd_addr_o and cmd_data_o equal to that cycle's address and data. cmd_op_o encodes 1 program, 2 identification entry, 3 identification exit, 4 bank erase, 5 block erase, 6 sector erase.
- R3: An erase sequence is: the two key cycles, then 5555h/80h, then 5555h/AAh, then 2AAAh/55h, then a sixth cycle. The sixth cycle gives op 4 for code 10h, which must be at address 5555h; op 5 for code 50h at any address, the block being address bits 18:15; or op 6 for code 30h at any address, the sector being bits 18:10. The pulse carries the sixth cycle's address and data.
- R4: The two key cycles followed by 5555h/90h give an op-2 pulse and set id_mode_o. The same keys followed by 5555h/F0h give an op-3 pulse and clear id_mode_o. id_mode_o changes on the same edge that raises the pulse.
- R5: While id_mode_o is 1, id_data_o is 0062h when rd_addr_i bits 18:0 are 0, 2595h when they are 1 and bit 19 is 0, 2596h when they are 1 and bit 19 is 1, and 0000h for any other offset. While id_mode_o is 0, id_data_o is 0000h.
- R6: Command cycles compare only address bits 14:0 and data bits 7:0; address bits 18:15 and data bits 15:8 have no effect on matching.
- R7: A cycle whose address or code does not match the expected step returns the decoder to its first step without a pulse. That cycle does not itself start a new sequence, and a sixth erase cycle with code 10h away from 5555h is such a mismatch.
- R8: A write cycle presented while busy_i is 1 is ignored. It neither advances nor breaks the sequence, and it never produces a pulse.
- R9: While id_mode_o is 1, only the exit sequence is accepted; a third cycle with A0h, 80h or 90h aborts the sequence without a pulse.
- R10: cmd_valid_o is high for exactly one clock, in the cycle after the edge that samples the final write cycle. The bank on cmd_bank_o is address bit 19 of that final cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_valid_i | input | 1 | One-clock strobe marking a host write cycle |
| wr_addr_i | input | 20 | Write cycle address, bit 19 selects the bank |
| wr_data_i | input | 16 | Write cycle data |
| busy_i | input | 1 | Array erase or program in progress |
| rd_addr_i | input | 20 | Read address used for identification readout |
| cmd_valid_o | output | 1 | One-cycle command pulse |
| cmd_op_o | output | 3 | Operation code of the pulse |
| cmd_bank_o | output | 1 | Target bank, from bit 19 of the final cycle |
| cmd_addr_o | output | 20 | Address of the final cycle |
| cmd_data_o | output | 16 | Data of the final cycle |
| id_mode_o | output | 1 | Identification mode active |
| id_data_o | output | 16 | Identification read data |

## Verification
The decoder is driven with complete program and erase sequences with clean key values, and with key cycles whose ignored upper address and data bits are filled with junk. This shows that the comparison is limited to the low fields. Broken sequences with a wrong second address or a misplaced bank-erase code, and sequences with busy cycles placed between the steps, show the difference between an abort and a cycle that is ignored. Identification entry is followed by program and erase attempts that must stay silent, and then by exit. The readout is probed at both banks and at offsets 0, 1 and 2, both inside and outside the mode.

// File: rtl/flash_unlock_pkg.sv
package flash_unlock_pkg;
  localparam int KEY_W  = 15;
  localparam int CODE_W = 8;

  localparam logic [KEY_W-1:0]  KEY_ADDR_A = 15'h5555;
  localparam logic [KEY_W-1:0]  KEY_ADDR_B = 15'h2AAA;
  localparam logic [CODE_W-1:0] KEY_CODE_A = 8'hAA;
  localparam logic [CODE_W-1:0] KEY_CODE_B = 8'h55;

  localparam logic [CODE_W-1:0] CODE_PROG     = 8'hA0;
  localparam logic [CODE_W-1:0] CODE_ID_ENTER = 8'h90;
  localparam logic [CODE_W-1:0] CODE_ID_EXIT  = 8'hF0;
  localparam logic [CODE_W-1:0] CODE_ERASE    = 8'h80;
  localparam logic [CODE_W-1:0] CODE_ER_BANK  = 8'h10;
  localparam logic [CODE_W-1:0] CODE_ER_BLOCK = 8'h50;
  localparam logic [CODE_W-1:0] CODE_ER_SECT  = 8'h30;

  typedef enum logic [2:0] {
    OP_NONE      = 3'd0,
    OP_PROG      = 3'd1,
    OP_ID_ENTER  = 3'd2,
    OP_ID_EXIT   = 3'd3,
    OP_ER_BANK   = 3'd4,
    OP_ER_BLOCK  = 3'd5,
    OP_ER_SECTOR = 3'd6
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_K1,
    ST_K2,
    ST_PROG,
    ST_E3,
    ST_E4,
    ST_E5
  } seq_e;
endpackage

// File: rtl/unlock_key_match.sv
module unlock_key_match
  import flash_unlock_pkg::*;
(
  input  logic [KEY_W-1:0]  key_addr_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              key_a_o,
  output logic              key_b_o,
  output logic              at_key_a_o
);
  assign at_key_a_o = (key_addr_i == KEY_ADDR_A);
  assign key_a_o    = at_key_a_o && (code_i == KEY_CODE_A);
  assign key_b_o    = (key_addr_i == KEY_ADDR_B) && (code_i == KEY_CODE_B);
endmodule

// File: rtl/unlock_seq_fsm.sv
module unlock_seq_fsm
  import flash_unlock_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  input  logic              busy_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              key_a_i,
  input  logic              key_b_i,
  input  logic              at_key_a_i,
  input  logic              id_mode_i,
  output logic              fire_o,
  output op_e               op_o,
  output logic              cmd_valid_o,
  output op_e               cmd_op_o,
  output logic              cmd_bank_o,
  output logic [ADDR_W-1:0] cmd_addr_o,
  output logic [DATA_W-1:0] cmd_data_o
);
  localparam int BANK_BIT = ADDR_W - 1;

  seq_e state_q, state_d;
  logic [CODE_W-1:0] code;
  logic take;

  assign code = wr_data_i[CODE_W-1:0];
  assign take = wr_valid_i && !busy_i;

  always_comb begin
    state_d = state_q;
    fire_o  = 1'b0;
    op_o    = OP_NONE;
    if (take) begin
      state_d = ST_IDLE;
      unique case (state_q)
        ST_IDLE: if (key_a_i) state_d = ST_K1;
        ST_K1:   if (key_b_i) state_d = ST_K2;
        ST_K2: begin
          if (at_key_a_i) begin
            case (code)
              CODE_PROG:  if (!id_mode_i) state_d = ST_PROG;
              CODE_ERASE: if (!id_mode_i) state_d = ST_E3;
              CODE_ID_ENTER: if (!id_mode_i) begin
                fire_o = 1'b1;
                op_o   = OP_ID_ENTER;
              end
              CODE_ID_EXIT: begin
                fire_o = 1'b1;
                op_o   = OP_ID_EXIT;
              end
              default: ;
            endcase
          end
        end
        ST_PROG: begin
          fire_o = 1'b1;
          op_o   = OP_PROG;
        end
        ST_E3: if (key_a_i) state_d = ST_E4;
        ST_E4: if (key_b_i) state_d = ST_E5;
        ST_E5: begin
          case (code)
            CODE_ER_BANK: if (at_key_a_i) begin
              fire_o = 1'b1;
              op_o   = OP_ER_BANK;
            end
            CODE_ER_BLOCK: begin
              fire_o = 1'b1;
              op_o   = OP_ER_BLOCK;
            end
            CODE_ER_SECT: begin
              fire_o = 1'b1;
              op_o   = OP_ER_SECTOR;
            end
            default: ;
          endcase
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      cmd_valid_o <= 1'b0;
      cmd_op_o    <= OP_NONE;
      cmd_bank_o  <= 1'b0;
      cmd_addr_o  <= '0;
      cmd_data_o  <= '0;
    end else begin
      state_q     <= state_d;
      cmd_valid_o <= fire_o;
      if (fire_o) begin
        cmd_op_o   <= op_o;
        cmd_bank_o <= wr_addr_i[BANK_BIT];
        cmd_addr_o <= wr_addr_i;
        cmd_data_o <= wr_data_i;
      end
    end
  end

  assert_busy_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && wr_valid_i) |=> $stable(state_q));
  assert_busy_silent_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> !cmd_valid_o);
  assert_pulse_single_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |=> !cmd_valid_o);
  assert_pulse_cause_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cmd_valid_o) |-> $past(wr_valid_i && !busy_i));
endmodule

// File: rtl/id_mode_unit.sv
module id_mode_unit
  import flash_unlock_pkg::*;
#(
  parameter int               ADDR_W   = 20,
  parameter int               DATA_W   = 16,
  parameter logic [DATA_W-1:0] MFR_CODE = 16'h0062,
  parameter logic [DATA_W-1:0] DEV_BASE = 16'h2595
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fire_i,
  input  op_e               op_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic              id_mode_o,
  output logic [DATA_W-1:0] id_data_o
);
  localparam int OFF_W = ADDR_W - 1;

  logic [OFF_W-1:0] offset;
  logic             bank;

  assign offset = rd_addr_i[OFF_W-1:0];
  assign bank   = rd_addr_i[ADDR_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            id_mode_o <= 1'b0;
    else if (fire_i && op_i == OP_ID_ENTER) id_mode_o <= 1'b1;
    else if (fire_i && op_i == OP_ID_EXIT)  id_mode_o <= 1'b0;
  end

  always_comb begin
    id_data_o = '0;
    if (id_mode_o) begin
      if (offset == OFF_W'(0))      id_data_o = MFR_CODE;
      else if (offset == OFF_W'(1)) id_data_o = DEV_BASE + DATA_W'(bank);
    end
  end

  assert_quiet_outside_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !id_mode_o |-> (id_data_o == '0));
endmodule

// File: rtl/flash_unlock_decoder.sv
module flash_unlock_decoder
  import flash_unlock_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              busy_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic              cmd_valid_o,
  output logic [2:0]        cmd_op_o,
  output logic              cmd_bank_o,
  output logic [ADDR_W-1:0] cmd_addr_o,
  output logic [DATA_W-1:0] cmd_data_o,
  output logic              id_mode_o,
  output logic [DATA_W-1:0] id_data_o
);
  logic key_a, key_b, at_key_a, fire;
  op_e  op_d, op_q;

  unlock_key_match u_match (
    .key_addr_i (wr_addr_i[KEY_W-1:0]),
    .code_i     (wr_data_i[CODE_W-1:0]),
    .key_a_o    (key_a),
    .key_b_o    (key_b),
    .at_key_a_o (at_key_a)
  );

  unlock_seq_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_valid_i  (wr_valid_i),
    .busy_i      (busy_i),
    .wr_addr_i   (wr_addr_i),
    .wr_data_i   (wr_data_i),
    .key_a_i     (key_a),
    .key_b_i     (key_b),
    .at_key_a_i  (at_key_a),
    .id_mode_i   (id_mode_o),
    .fire_o      (fire),
    .op_o        (op_d),
    .cmd_valid_o (cmd_valid_o),
    .cmd_op_o    (op_q),
    .cmd_bank_o  (cmd_bank_o),
    .cmd_addr_o  (cmd_addr_o),
    .cmd_data_o  (cmd_data_o)
  );

  assign cmd_op_o = op_q;

  id_mode_unit #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_id (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .fire_i    (fire),
    .op_i      (op_d),
    .rd_addr_i (rd_addr_i),
    .id_mode_o (id_mode_o),
    .id_data_o (id_data_o)
  );

  assert_id_enter_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(id_mode_o) |-> (cmd_valid_o && cmd_op_o == OP_ID_ENTER));
  assert_id_leave_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(id_mode_o) |-> (cmd_valid_o && cmd_op_o == OP_ID_EXIT));
  assert_id_exit_only_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(id_mode_o) && cmd_valid_o) |-> (cmd_op_o == OP_ID_EXIT));
  assert_bank_erase_key_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && cmd_op_o == OP_ER_BANK) |-> (cmd_addr_o[KEY_W-1:0] == KEY_ADDR_A));
  assert_bank_bit_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> (cmd_bank_o == cmd_addr_o[ADDR_W-1]));
endmodule

// File: tb/flash_unlock_decoder_bench.sv
module flash_unlock_decoder_bench;
  localparam int CLK_P = 10;
  localparam int AW = 20;
  localparam int DW = 16;

  typedef struct packed {
    logic          busy;
    logic [AW-1:0] a;
    logic [DW-1:0] d;
    logic          ev;
    logic [2:0]    eop;
    logic          eid;
    logic [3:0]    rq;
  } vec_t;

  localparam int NV = 59;
  localparam vec_t VEC [NV] = '{
    // R2 program
    '{1'b0, 20'h05555, 16'h00AA, 1'b0, 3'd0, 1'b0, 4'd2},
    '{1'b0, 20'h02AAA, 16'h0055, 1'b0, 3'd0, 1'b0, 4'd2},
    '{1'b0, 20'h05555, 16'h00A0, 1'b0, 3'd0, 1'b0, 4'd2},
    '{1'b0, 20'h81234, 16'hBEEF, 1'b1, 3'd1, 1'b0, 4'd2},
    // R6 junk in ignored bits
    '{1'b0, 20'h7D555, 16'hFFAA, 1'b0, 3'd0, 1'b0, 4'd6},
    '{1'b0, 20'h7AAAA, 16'h1255, 1'b0, 3'd0, 1'b0, 4'd6},
    '{1'b0, 20'h45555, 16'h33A0, 1'b0, 3'd0, 1'b0, 4'd6},
    '{1'b0, 20'h00010, 16'h0000, 1'b1, 3'd1, 1'b0, 4'd6},
    // R3 sector erase
    '{1'b0, 20'h05555, 16'h00AA, 1'b0, 3'd0, 1'b0, 4'd3},
    '{1'b0, 20'h02AAA, 16'h0055, 1'b0, 3'd0, 1'b0, 4'd3},
    '{1'b0, 20'h05555, 16'h0080, 1'b0, 3'd0, 1'b0, 4'd3},
    '{1'b0, 20'h05555, 16'h00AA, 1'b0, 3'd0, 1'b0, 4'd3},
    '{1'b0, 20'h02AAA, 16'h0055, 1'b0, 3'd0, 1'b0, 4'd3},
    '{1'b0, 20'h80400, 16'h0030, 1'b1, 3'd6, 1'b0, 4'd3},
    // R3 block erase
    '{1'b0, 20'h05555, 16'h00AA, 1'b0, 3'd0, 1'b0, 4'd3},
    '{1'b0, 20'h02AAA, 16'h0055, 1'b0, 3'd0, 1'b0, 4'd3},
    '{1'b0, 20'h05555, 16'h0080, 1'b0, 3'd0, 1'b0, 4'd3},
    '{1'b0, 20'h05555, 16'h00AA, 1'b0, 3'd0, 1'b0, 4'd3},
    '{1'b0, 20'h02AAA, 16'h0055, 1'b0, 3'd0, 1'b0, 4'd3},
    '{1'b0, 20'h08000, 16'h0050, 1'b1, 3'd5, 1'b0, 4'd3},
    // R3 bank erase, upper data junk
    '{1'b0, 20'h05555, 16'h00AA, 1'b0, 3'd0, 1'b0, 4'd3},
    '{1'b0, 20'h02AAA, 16'h0055, 1'b0, 3'd0, 1'b0, 4'd3},
    '{1'b0, 20'h05555, 16'h0080, 1'b0, 3'd0, 1'b0, 4'd3},
    '{1'b0, 20'h05555, 16'h00AA, 1'b0, 3'd0, 1'b0, 4'd3},
    '{1'b0, 20'h02AAA, 16'h0055, 1'b0, 3'd0, 1'b0, 4'd3},
    '{1'b0, 20'h85555, 16'hAB10, 1'b1, 3'd4, 1'b0, 4'd3},
    // R7 bank erase code away from key address
    '{1'b0, 20'h05555, 16'h00AA, 1'b0, 3'd0, 1'b0, 4'd7},
    '{1'b0, 20'h02AAA, 16'h0055, 1'b0, 3'd0, 1'b0, 4'd7},
    '{1'b0, 20'h05555, 16'h0080, 1'b0, 3'd0, 1'b0, 4'd7},
    '{1'b0, 20'h05555, 16'h00AA, 1'b0, 3'd0, 1'b0, 4'd7},
    '{1'b0, 20'h02AAA, 16'h0055, 1'b0, 3'd0, 1'b0, 4'd7},
    '{1'b0, 20'h01234, 16'h0010, 1'b0, 3'd0, 1'b0, 4'd7},
    // R7 wrong second address, no resync
    '{1'b0, 20'h05555, 16'h00AA, 1'b0, 3'd0, 1'b0, 4'd7},
    '{1'b0, 20'h02AAB, 16'h0055, 1'b0, 3'd0, 1'b0, 4'd7},
    '{1'b0, 20'h05555, 16'h00A0, 1'b0, 3'd0, 1'b0, 4'd7},
    '{1'b0, 20'h00300, 16'h1234, 1'b0, 3'd0, 1'b0, 4'd7},
    // R8 busy cycles interleaved
    '{1'b0, 20'h05555, 16'h00AA, 1'b0, 3'd0, 1'b0, 4'd8},
    '{1'b1, 20'h01234, 16'h0000, 1'b0, 3'd0, 1'b0, 4'd8},
    '{1'b0, 20'h02AAA, 16'h0055, 1'b0, 3'd0, 1'b0, 4'd8},
    '{1'b1, 20'h05555, 16'h00AA, 1'b0, 3'd0, 1'b0, 4'd8},
    '{1'b0, 20'h05555, 16'h00A0, 1'b0, 3'd0, 1'b0, 4'd8},
    '{1'b1, 20'h00200, 16'h2222, 1'b0, 3'd0, 1'b0, 4'd8},
    '{1'b0, 20'h00100, 16'h1111, 1'b1, 3'd1, 1'b0, 4'd8},
    // R8 whole ID entry while busy
    '{1'b1, 20'h05555, 16'h00AA, 1'b0, 3'd0, 1'b0, 4'd8},
    '{1'b1, 20'h02AAA, 16'h0055, 1'b0, 3'd0, 1'b0, 4'd8},
    '{1'b1, 20'h05555, 16'h0090, 1'b0, 3'd0, 1'b0, 4'd8},
    // R4 ID entry on bank 2
    '{1'b0, 20'h05555, 16'h00AA, 1'b0, 3'd0, 1'b0, 4'd4},
    '{1'b0, 20'h02AAA, 16'h0055, 1'b0, 3'd0, 1'b0, 4'd4},
    '{1'b0, 20'h85555, 16'h0090, 1'b1, 3'd2, 1'b1, 4'd4},
    // R9 program and erase refused in ID mode
    '{1'b0, 20'h05555, 16'h00AA, 1'b0, 3'd0, 1'b1, 4'd9},
    '{1'b0, 20'h02AAA, 16'h0055, 1'b0, 3'd0, 1'b1, 4'd9},
    '{1'b0, 20'h05555, 16'h00A0, 1'b0, 3'd0, 1'b1, 4'd9},
    '{1'b0, 20'h01234, 16'h5678, 1'b0, 3'd0, 1'b1, 4'd9},
    '{1'b0, 20'h05555, 16'h00AA, 1'b0, 3'd0, 1'b1, 4'd9},
    '{1'b0, 20'h02AAA, 16'h0055, 1'b0, 3'd0, 1'b1, 4'd9},
    '{1'b0, 20'h05555, 16'h0080, 1'b0, 3'd0, 1'b1, 4'd9},
    // R4 exit
    '{1'b0, 20'h05555, 16'h00AA, 1'b0, 3'd0, 1'b1, 4'd4},
    '{1'b0, 20'h02AAA, 16'h0055, 1'b0, 3'd0, 1'b1, 4'd4},
    '{1'b0, 20'h05555, 16'h00F0, 1'b1, 3'd3, 1'b0, 4'd4}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_valid = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic          busy = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic          cmd_valid;
  logic [2:0]    cmd_op;
  logic          cmd_bank;
  logic [AW-1:0] cmd_addr;
  logic [DW-1:0] cmd_data;
  logic          id_mode;
  logic [DW-1:0] id_data;

  int checks = 0;
  int errors = 0;

  always #(CLK_P/2) clk = ~clk;

  flash_unlock_decoder u_flash_unlock_decoder (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .wr_valid_i  (wr_valid),
    .wr_addr_i   (wr_addr),
    .wr_data_i   (wr_data),
    .busy_i      (busy),
    .rd_addr_i   (rd_addr),
    .cmd_valid_o (cmd_valid),
    .cmd_op_o    (cmd_op),
    .cmd_bank_o  (cmd_bank),
    .cmd_addr_o  (cmd_addr),
    .cmd_data_o  (cmd_data),
    .id_mode_o   (id_mode),
    .id_data_o   (id_data)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // drive one write cycle; returns at the negedge after the sampling edge
  task automatic wr(input logic b, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    wr_valid = 1'b1;
    busy     = b;
    wr_addr  = a;
    wr_data  = d;
    @(negedge clk);
    wr_valid = 1'b0;
    busy     = 1'b0;
  endtask

  task automatic id_read(input logic [AW-1:0] a, input logic [DW-1:0] exp);
    rd_addr = a;
    #1;
    check("R5", "id_data", 32'(id_data), 32'(exp));
  endtask

  initial begin
    #(CLK_P * 20000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1 reset state
    #(CLK_P * 2 + 1);
    check("R1", "cmd_valid in reset", 32'(cmd_valid), 32'd0);
    check("R1", "id_mode in reset", 32'(id_mode), 32'd0);
    check("R1", "id_data in reset", 32'(id_data), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "cmd_valid after reset", 32'(cmd_valid), 32'd0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      string rq;
      rq = $sformatf("R%0d", VEC[i].rq);
      wr(VEC[i].busy, VEC[i].a, VEC[i].d);
      check(rq, $sformatf("row %0d cmd_valid", i), 32'(cmd_valid), 32'(VEC[i].ev));
      if (VEC[i].ev) begin
        check(rq, $sformatf("row %0d op", i), 32'(cmd_op), 32'(VEC[i].eop));
        check(rq, $sformatf("row %0d addr", i), 32'(cmd_addr), 32'(VEC[i].a));
        check(rq, $sformatf("row %0d data", i), 32'(cmd_data), 32'(VEC[i].d));
        check("R10", $sformatf("row %0d bank", i), 32'(cmd_bank), 32'(VEC[i].a[AW-1]));
      end
      check(rq, $sformatf("row %0d id_mode", i), 32'(id_mode), 32'(VEC[i].eid));
      @(negedge clk);
      check("R10", $sformatf("row %0d pulse width", i), 32'(cmd_valid), 32'd0);
    end

    // R5 readout inside and outside ID mode
    wr(1'b0, 20'h05555, 16'h00AA);
    wr(1'b0, 20'h02AAA, 16'h0055);
    wr(1'b0, 20'h05555, 16'h0090);
    check("R4", "id_mode after entry", 32'(id_mode), 32'd1);
    id_read(20'h00000, 16'h0062);
    id_read(20'h00001, 16'h2595);
    id_read(20'h80001, 16'h2596);
    id_read(20'h80000, 16'h0062);
    id_read(20'h00002, 16'h0000);
    id_read(20'h08001, 16'h0000);
    wr(1'b0, 20'h05555, 16'h00AA);
    wr(1'b0, 20'h02AAA, 16'h0055);
    wr(1'b0, 20'h05555, 16'h00F0);
    check("R4", "id_mode after exit", 32'(id_mode), 32'd0);
    id_read(20'h00001, 16'h0000);
    id_read(20'h00000, 16'h0000);

    // R1 reset in mid-sequence clears the position
    wr(1'b0, 20'h05555, 16'h00AA);
    wr(1'b0, 20'h02AAA, 16'h0055);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    wr(1'b0, 20'h05555, 16'h00A0);
    check("R1", "no pulse after cut sequence", 32'(cmd_valid), 32'd0);
    wr(1'b0, 20'h00444, 16'h4444);
    check("R1", "no program after cut sequence", 32'(cmd_valid), 32'd0);

    // R10 back-to-back program sequences, pulse lands one cycle after the final write
    wr(1'b0, 20'h05555, 16'h00AA);
    wr(1'b0, 20'h02AAA, 16'h0055);
    wr(1'b0, 20'h05555, 16'h00A0);
    @(negedge clk);
    wr_valid = 1'b1;
    wr_addr  = 20'h8ABCD;
    wr_data  = 16'h0F0F;
    #1;
    check("R10", "pulse not before edge", 32'(cmd_valid), 32'd0);
    @(negedge clk);
    wr_valid = 1'b0;
    check("R10", "pulse after edge", 32'(cmd_valid), 32'd1);
    check("R10", "bank of final cycle", 32'(cmd_bank), 32'd1);
    check("R2", "program address", 32'(cmd_addr), 32'h8ABCD);
    @(negedge clk);
    check("R10", "pulse gone", 32'(cmd_valid), 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule